// File: doc/BRIEF.md
# Line-Modulated Off-Time PWM Cycle Timer

This block times each switching cycle of a peak-current-mode boost power-factor stage. The gate turns on and stays high until a current-sense comparator reports that the switch current has reached its reference. The gate then turns off. During the off interval a ramp counter advances once per clock. The next on-time starts when the ramp reaches a target code, which is the sampled rectified-line code. Because the off-time scales with the instantaneous line voltage, the switching period stays nearly constant while the inductor current is continuous.

A soft-start input replaces the line code with a large fixed target, so that the first cycles get long off intervals. A separate check compares the line peak code with the shortest usable off-time and raises a flag when that peak would program too short an interval. At 100 MHz with one ramp step per clock, a line code of 308 stands for 1 V and gives a 3.09 µs off-time.

Top module: `lmfot_pwm_timer`

## Requirements
- R1: While the gate is low and the block is enabled, the ramp advances by one each clock, and the off interval lasts exactly target+1 clocks. While the gate is high the ramp stays at zero.
- R2: At the clock edge where the ramp is at or above the target, the gate goes high and the ramp is cleared to zero on that same edge.
- R3: A trip flag sampled high while the gate is high drives the gate low at that clock edge.
- R4: A trip flag sampled while the gate is low is ignored. The off interval still lasts target+1 clocks.
- R5: The target is the line code `mult_code`, so the off-time follows it. Code 308 gives 309 clocks (3.09 µs at 100 MHz), and a larger code gives a longer interval.
- R6: While `soft_start` is high, the target is SS_CODE (default 1263, about 4.1 V), which gives an off interval of 1264 clocks.
- R7: `toff_short` is registered. One clock after `pk_code` is sampled below MIN_PK_CODE (default 144, a 1.45 µs interval), it reads 1. Otherwise it reads 0.
- R8: When `enable` is low, `gate` is low in the same cycle without waiting for a clock edge, and the ramp is held at zero. After `enable` returns, the off interval lasts target+1 clocks counted from its return.
- R9: A target of 0 gives a one-clock off interval, and the gate then turns on again.
- R10: During reset `gate` and `toff_short` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces the gate off |
| soft_start | input | 1 | Replace the target with SS_CODE |
| mult_code | input | MULT_W | Sampled rectified-line code |
| pk_code | input | MULT_W | Held line peak code |
| trip | input | 1 | Current-sense comparator trip |
| gate | output | 1 | Gate command |
| toff_short | output | 1 | Peak off-time below the minimum |

## Verification
A wrong ramp value or a wrong gate phase shows up at `gate` as an off interval of the wrong length. The error appears by the end of the same switching cycle, which is at most target+1 clocks after the gate falls. A ramp that does not clear on turn-on shortens the next off interval. A latch that responds to a trip during the off interval ends nothing visible, so the bench compares every interval length with target+1 while trips arrive in the off phase. A cycle-level model checks every sampled clock under random line codes, trips, enables and soft-start, so a divergence is reported in the cycle where it occurs.

// File: rtl/lmfot_pkg.sv
package lmfot_pkg;
  typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} pwm_phase_t;

  function automatic int unsigned div_width(input int unsigned div);
    return (div <= 2) ? 1 : $clog2(div);
  endfunction
endpackage

// File: rtl/lmfot_target_sel.sv
module lmfot_target_sel #(
  parameter int MULT_W      = 11,
  parameter int SS_CODE     = 1263,
  parameter int MIN_PK_CODE = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_start,
  input  logic [MULT_W-1:0] mult_code,
  input  logic [MULT_W-1:0] pk_code,
  output logic [MULT_W-1:0] tgt,
  output logic              toff_short
);
  localparam logic [MULT_W-1:0] SS_TGT = MULT_W'(SS_CODE);
  localparam logic [MULT_W-1:0] PK_MIN = MULT_W'(MIN_PK_CODE);

  logic short_d;
  logic short_q;

  always_comb begin
    tgt = soft_start ? SS_TGT : mult_code;
  end

  always_comb begin
    short_d = (pk_code < PK_MIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) short_q <= 1'b0;
    else        short_q <= short_d;
  end

  assign toff_short = short_q;
endmodule

// File: rtl/lmfot_off_ramp.sv
module lmfot_off_ramp
  import lmfot_pkg::*;
#(
  parameter int MULT_W   = 11,
  parameter int RAMP_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              gate_on,
  input  logic [MULT_W-1:0] tgt,
  output logic [MULT_W-1:0] ramp,
  output logic              hit
);
  localparam int DW = div_width(RAMP_DIV);

  logic              step;
  logic              ramp_en;
  logic [MULT_W-1:0] ramp_d;
  logic [MULT_W-1:0] ramp_q;

  generate
    if (RAMP_DIV <= 1) begin : g_nodiv
      assign step = 1'b1;
    end else begin : g_div
      logic [DW-1:0] div_q;
      logic [DW-1:0] div_d;
      logic          div_last;
      assign div_last = (div_q == DW'(RAMP_DIV - 1));
      always_comb begin
        if (!enable || gate_on) div_d = '0;
        else if (div_last)      div_d = '0;
        else                    div_d = div_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
      assign step = div_last;
    end
  endgenerate

  always_comb begin
    hit = enable && !gate_on && step && (ramp_q >= tgt);
  end

  always_comb begin
    ramp_en = 1'b1;
    if (!enable || gate_on || hit) begin
      ramp_d = '0;
    end else if (step) begin
      ramp_d = ramp_q + 1'b1;
    end else begin
      ramp_d  = ramp_q;
      ramp_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ramp_q <= '0;
    else if (ramp_en) ramp_q <= ramp_d;
  end

  assign ramp = ramp_q;
endmodule

// File: rtl/lmfot_pwm_latch.sv
module lmfot_pwm_latch
  import lmfot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_req,
  input  logic trip,
  output logic gate_on
);
  pwm_phase_t ph_d;
  pwm_phase_t ph_q;

  always_comb begin
    ph_d = ph_q;
    if (!enable) begin
      ph_d = PH_OFF;
    end else begin
      unique case (ph_q)
        PH_ON:  if (trip)    ph_d = PH_OFF;
        PH_OFF: if (set_req) ph_d = PH_ON;
        default:             ph_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_OFF;
    else        ph_q <= ph_d;
  end

  assign gate_on = (ph_q == PH_ON);
endmodule

// File: rtl/lmfot_pwm_timer.sv
module lmfot_pwm_timer #(
  parameter int MULT_W      = 11,
  parameter int SS_CODE     = 1263,
  parameter int MIN_PK_CODE = 144,
  parameter int RAMP_DIV    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              soft_start,
  input  logic [MULT_W-1:0] mult_code,
  input  logic [MULT_W-1:0] pk_code,
  input  logic              trip,
  output logic              gate,
  output logic              toff_short
);
  logic [1:0]        rst_pipe;
  logic              rst_q_n;
  logic [MULT_W-1:0] tgt;
  logic [MULT_W-1:0] ramp;
  logic              hit;
  logic              gate_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  lmfot_target_sel #(
    .MULT_W(MULT_W), .SS_CODE(SS_CODE), .MIN_PK_CODE(MIN_PK_CODE)
  ) tsel_i (
    .clk(clk), .rst_n(rst_q_n), .soft_start(soft_start),
    .mult_code(mult_code), .pk_code(pk_code),
    .tgt(tgt), .toff_short(toff_short)
  );

  lmfot_off_ramp #(
    .MULT_W(MULT_W), .RAMP_DIV(RAMP_DIV)
  ) ramp_i (
    .clk(clk), .rst_n(rst_q_n), .enable(enable), .gate_on(gate_on),
    .tgt(tgt), .ramp(ramp), .hit(hit)
  );

  lmfot_pwm_latch latch_i (
    .clk(clk), .rst_n(rst_q_n), .enable(enable),
    .set_req(hit), .trip(trip), .gate_on(gate_on)
  );

  assign gate = gate_on & enable;
endmodule

// File: rtl/lmfot_pwm_timer_chk.sv
module lmfot_pwm_timer_chk #(
  parameter int MULT_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              trip,
  input logic              gate_on,
  input logic [MULT_W-1:0] ramp,
  input logic [MULT_W-1:0] tgt
);
  AST_RAMP_IDLE_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> (ramp == '0)); // R1

  AST_TURN_ON_CLEARS_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> (ramp == '0)); // R2

  AST_TRIP_ENDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && trip) |=> !gate_on); // R3

  AST_OFF_HOLDS_BELOW_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !gate_on && (ramp < tgt)) |=> !gate_on); // R4

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!gate_on && (ramp == '0))); // R8
endmodule

bind lmfot_pwm_timer lmfot_pwm_timer_chk #(.MULT_W(MULT_W)) chk_i (
  .clk(clk), .rst_n(rst_q_n), .enable(enable), .trip(trip),
  .gate_on(gate_on), .ramp(ramp), .tgt(tgt)
);

// File: tb/lmfot_pwm_timer_tb.sv
`timescale 1ns/1ps
module lmfot_pwm_timer_tb_top;
  localparam int MULT_W  = 11;
  localparam int SS_CODE = 1263;
  localparam int MIN_PK  = 144;

  logic              clk;
  logic              rst_n;
  logic              enable;
  logic              soft_start;
  logic [MULT_W-1:0] mult_code;
  logic [MULT_W-1:0] pk_code;
  logic              trip;
  logic              gate;
  logic              toff_short;

  int tests;
  int fails;
  int cyc;
  bit done;
  bit m_g;
  int m_r;
  bit m_f;
  bit last_gate;

  lmfot_pwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_start(soft_start),
    .mult_code(mult_code), .pk_code(pk_code), .trip(trip),
    .gate(gate), .toff_short(toff_short)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_tgt(input bit ss, input int mc);
    return ss ? SS_CODE : mc;
  endfunction

  // one clock: drive at negedge, check, then advance model at posedge
  task automatic step(input bit en, input bit ss, input int mc, input int pk,
                      input bit tr, input string tag);
    int t;
    enable = en; soft_start = ss; mult_code = MULT_W'(mc);
    pk_code = MULT_W'(pk); trip = tr;
    #1;
    last_gate = gate;
    chk({tag, " gate"}, int'(gate), int'(m_g && en));
    chk("R7 toff_short", int'(toff_short), int'(m_f));
    @(posedge clk);
    t = exp_tgt(ss, mc);
    m_f = (pk < MIN_PK);
    if (!en) begin m_g = 0; m_r = 0; end
    else if (m_g) begin if (tr) m_g = 0; m_r = 0; end
    else if (m_r >= t) begin m_g = 1; m_r = 0; end
    else m_r = m_r + 1;
    @(negedge clk);
  endtask

  // reach gate high, trip once, count low clocks until the gate rises
  task automatic meas_off(input bit ss, input int mc, input bit trip_off,
                          input int exp, input string tag);
    int n;
    int guard;
    guard = 0;
    while (!m_g && guard < 3000) begin
      step(1, ss, mc, 500, 0, tag); guard++;
    end
    step(1, ss, mc, 500, 1, "R3");
    n = 0;
    step(1, ss, mc, 500, trip_off, tag);
    while (!last_gate && n < 3000) begin
      n++;
      step(1, ss, mc, 500, trip_off, tag);
    end
    chk({tag, " off length"}, n, exp);
  endtask

  initial begin
    int seed;
    int n;
    tests = 0; fails = 0; cyc = 0; done = 0;
    m_g = 0; m_r = 0; m_f = 0;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; enable = 0; soft_start = 0; mult_code = '0;
    pk_code = MULT_W'(500); trip = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 gate in reset", int'(gate), 0);
    chk("R10 toff_short in reset", int'(toff_short), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 0, 500, 0, "R10");

    meas_off(0, 308, 0, 309, "R5");          // 3.09 us at 1 V
    meas_off(0, 100, 0, 101, "R1");
    meas_off(0, 0,   0, 1,   "R9");
    meas_off(0, 50,  1, 51,  "R4");          // trips during off ignored
    meas_off(1, 7,   0, SS_CODE + 1, "R6");
    meas_off(0, 20,  0, 21,  "R2");

    // enable drop while on: gate low in the same cycle
    while (!m_g) step(1, 0, 30, 500, 0, "R8");
    enable = 0; #1;
    chk("R8 gate low at once", int'(gate), 0);
    @(negedge clk);
    repeat (4) step(0, 0, 30, 500, 0, "R8");
    n = 0;
    step(1, 0, 30, 500, 0, "R8");
    while (!last_gate && n < 100) begin n++; step(1, 0, 30, 500, 0, "R8"); end
    chk("R8 off after re-enable", n, 31);

    // peak code limit
    step(1, 0, 10, 143, 0, "R7");
    step(1, 0, 10, 144, 0, "R7");
    step(1, 0, 10, 0,   0, "R7");
    step(1, 0, 10, 2047, 0, "R7");

    // random stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      bit en;
      bit ss;
      bit tr;
      int mc;
      int pk;
      en = ($urandom_range(99) < 96);
      ss = ($urandom_range(199) == 0);
      tr = ($urandom_range(9) < 3);
      mc = $urandom_range(40);
      pk = $urandom_range(300);
      step(en, ss, mc, pk, tr, "R1 R2 R3 R4");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule